// File: doc/BRIEF.md
# Page Table Walk Refill Controller

This block services a translation miss. A miss names one of sixteen on-chip pointer registers and a page number. The block adds the two to form the address of a page entry. It reads that entry from memory through a request/done handshake, then looks at its type. A private entry ends the walk. A shared entry sends the walk into the shared table. An indirect entry either goes through the indirect pointer table or picks an on-chip pointer directly. While the walk goes on, the permission bits of every level are ANDed together. At the end the block gives out one refill record: read/write/execute permissions, a real page number and a fault code. The map storage uses this record.

The walk can stop with a fault in four ways. An entry may deny access. The chain of shared and indirect steps may grow too deep. The walker's own memory reference may fault. A user-class page number may lie beyond the length held in its pointer. If the walker's own fetch misses in the map, the block drops the walk and raises a busy flag. While that flag is up, only misses flagged as coming from the walker start a new walk. The requester that was dropped simply asks again later.

Top module: `ptw_refill`

## Requirements
- R1: After reset, refillValid, memReq and busy are all 0.
- R2: A pointer register is written with ptrWrData = {length[10:0], base[21:0]}. When a miss is accepted in idle, memReq is high for exactly one cycle, in the next cycle. In that cycle memAddr = base of pointer missPtrSel + missPage.
- R3: Entries are 36 bits. Bits [35:34] give the type (00 private, 01 shared, 10 indirect, 11 treated as no-access). Bits [33:31] are the read, write and execute permissions, and bit [30] is the access bit. A private entry with bit [30] set ends the walk. refillValid then pulses for one cycle with refillFault = 0, refillPage = entry[12:0], and refillPerm = the entry's permissions ANDed with those of every earlier level.
- R4: A private entry with bit [30] clear ends the walk with refillFault = 1 (no access).
- R5: After a shared entry, the next fetch is at base of pointer 6 + entry[26:14]. The shared entry's permissions narrow the result.
- R6: An indirect entry with entry[26:18] not all ones leads to a fetch at base of pointer 7 + entry[26:14]. That word is a pointer word: bit [30] is its access bit, [33:31] its permissions and [21:0] a new base. The fetch after it is at new base + the indirect entry's [8:0]. Both levels narrow the permissions, and a pointer word with bit [30] clear gives refillFault = 1.
- R7: An indirect entry with entry[26:18] all ones leads to a fetch at base of pointer entry[17:14] + entry[8:0].
- R8: For pointers 4 and 5, a missPage larger than the pointer's length field gives refillFault = 4 in the next cycle, and memReq stays low. Other pointers ignore their length field.
- R9: If a shared or indirect entry arrives after MAX_DEPTH such steps have already been followed, the walk ends with refillFault = 2.
- R10: If memFault is high together with memDone, the walk ends with refillFault = 3.
- R11: If memMiss arrives while waiting, the walk ends with no refill and busy is set. While busy is set, a miss with missFromWalker = 0 starts no fetch. busy clears when a walk started by a missFromWalker = 1 request ends.
- R12: Every fault outcome gives refillPerm = 000 and refillPage = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ptrWrEn | input | 1 | Write strobe for a pointer register |
| ptrWrIdx | input | 4 | Pointer register to write |
| ptrWrData | input | 33 | {length, base} pointer value |
| missValid | input | 1 | A map miss requests a walk |
| missFromWalker | input | 1 | The miss came from the walker's own fetch |
| missPtrSel | input | 4 | Pointer register for the first lookup |
| missPage | input | 13 | Page number for the first lookup |
| memReq | output | 1 | Four-word read request, one cycle |
| memAddr | output | 22 | Address of the page entry to read |
| memDone | input | 1 | Read has completed, memData valid |
| memData | input | 36 | Fetched entry word |
| memFault | input | 1 | The walker's reference faulted (with memDone) |
| memMiss | input | 1 | The walker's reference missed in the map |
| refillValid | output | 1 | Refill record valid, one cycle |
| refillPerm | output | 3 | Read/write/execute permissions for the map |
| refillPage | output | 13 | Real page number for the map |
| refillFault | output | 3 | 0 none, 1 no access, 2 too deep, 3 walk fault, 4 out of bounds |
| busy | output | 1 | Walker is refilling its own paging data |

## Verification
The bench builds the block with MAX_DEPTH set to 2. With that value the too-deep fault is reached after only three chained shared entries, instead of five. The other parameters keep their defaults: 22-bit addresses, 13-bit indexes and 11-bit lengths. This lets the expected addresses be worked out by hand, both for pointer-plus-page sums and for the direct-pointer indirect path through an unassigned pointer.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int NPTR  = 16;   // fixed by the 4-bit direct selector field
  localparam int ENT_W = 36;
  localparam int PAGE_W = 13;

  typedef enum logic [2:0] {
    F_NONE = 3'd0, F_NOACC = 3'd1, F_DEEP = 3'd2, F_WALK = 3'd3, F_BOUNDS = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    S_NONE, S_START, S_SHARED, S_INDTBL, S_INDDIR, S_PTRWORD
  } step_e;

  typedef enum logic [2:0] {
    K_PRIV, K_NACK, K_SHARED, K_INDTBL, K_INDDIR
  } kind_e;

  typedef struct packed {
    step_e step;
    logic  capture;
    logic  clr;
  } ctl_s;
endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int IDX_W  = 13,
  parameter int LEN_W  = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ptrWrEn,
  input  logic [3:0]              ptrWrIdx,
  input  logic [LEN_W+ADDR_W-1:0] ptrWrData,
  input  logic [3:0]              missPtrSel,
  input  logic [IDX_W-1:0]        missPage,
  input  logic [ENT_W-1:0]        memData,
  input  ctl_s                    ctl,
  output logic [ADDR_W-1:0]       memAddr,
  output kind_e                   kind,
  output logic                    ptrWordOk,
  output logic                    boundsFail,
  output logic [2:0]              refillPerm,
  output logic [PAGE_W-1:0]       refillPage
);
  localparam int PTR_W = LEN_W + ADDR_W;

  logic [PTR_W-1:0]  ptrQ [NPTR];
  logic [ADDR_W-1:0] baseQ;
  logic [IDX_W-1:0]  idxQ;
  logic [8:0]        pnQ;
  logic [2:0]        permQ;
  logic [2:0]        permQr;
  logic [PAGE_W-1:0] pageQr;

  logic [2:0] entPerm;
  logic       entAcc;
  assign entPerm = memData[33:31];
  assign entAcc  = memData[30];

  function automatic logic [ADDR_W-1:0] baseOf(input logic [PTR_W-1:0] p);
    return p[ADDR_W-1:0];
  endfunction

  // pointer register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NPTR; i++) ptrQ[i] <= '0;
    end else if (ptrWrEn) begin
      ptrQ[ptrWrIdx] <= ptrWrData;
    end
  end

  // entry classification
  always_comb begin
    unique case (memData[35:34])
      2'b00:   kind = entAcc ? K_PRIV : K_NACK;
      2'b01:   kind = K_SHARED;
      2'b10:   kind = (&memData[26:18]) ? K_INDDIR : K_INDTBL;
      default: kind = K_NACK;
    endcase
  end
  assign ptrWordOk = entAcc;

  logic [LEN_W-1:0] selLen;
  assign selLen = ptrQ[missPtrSel][PTR_W-1:ADDR_W];
  assign boundsFail = (missPtrSel == 4'd4 || missPtrSel == 4'd5) &&
                      ({{IDX_W{1'b0}}, missPage} > {{(IDX_W+LEN_W-IDX_W){1'b0}}, {IDX_W{1'b0}}} + (IDX_W+LEN_W)'(selLen));

  assign memAddr = baseQ + ADDR_W'(idxQ);

  // walk state registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0; idxQ <= '0; pnQ <= '0; permQ <= '0;
    end else begin
      unique case (ctl.step)
        S_START: begin
          baseQ <= baseOf(ptrQ[missPtrSel]);
          idxQ  <= missPage;
          permQ <= 3'b111;
        end
        S_SHARED: begin
          baseQ <= baseOf(ptrQ[6]);
          idxQ  <= IDX_W'(memData[26:14]);
          permQ <= permQ & entPerm;
        end
        S_INDTBL: begin
          baseQ <= baseOf(ptrQ[7]);
          idxQ  <= IDX_W'(memData[26:14]);
          pnQ   <= memData[8:0];
          permQ <= permQ & entPerm;
        end
        S_INDDIR: begin
          baseQ <= baseOf(ptrQ[memData[17:14]]);
          idxQ  <= IDX_W'(memData[8:0]);
          permQ <= permQ & entPerm;
        end
        S_PTRWORD: begin
          baseQ <= memData[ADDR_W-1:0];
          idxQ  <= IDX_W'(pnQ);
          permQ <= permQ & entPerm;
        end
        default: ;
      endcase
    end
  end

  // refill record
  always_ff @(posedge clk) begin
    if (!rstN) begin
      permQr <= '0; pageQr <= '0;
    end else if (ctl.clr) begin
      permQr <= '0; pageQr <= '0;
    end else if (ctl.capture) begin
      permQr <= permQ & entPerm;
      pageQr <= memData[PAGE_W-1:0];
    end
  end
  assign refillPerm = permQr;
  assign refillPage = pageQr;

  p_fault_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clr |=> (refillPerm == 3'b000 && refillPage == '0));
endmodule

// File: rtl/ptw_control.sv
module ptw_control
  import ptw_pkg::*;
#(
  parameter int MAX_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       missValid,
  input  logic       missFromWalker,
  input  logic       memDone,
  input  logic       memFault,
  input  logic       memMiss,
  input  kind_e      kind,
  input  logic       ptrWordOk,
  input  logic       boundsFail,
  output ctl_s       ctl,
  output logic       memReq,
  output logic       refillValid,
  output logic [2:0] refillFault,
  output logic       busy
);
  localparam int DW = $clog2(MAX_DEPTH + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT} st_e;

  st_e          stQ, nxt;
  logic [DW-1:0] depthQ;
  logic         inPtrQ, fromWalkerQ, busyQ, validQ;
  fault_e       faultQ, fcode;
  logic         finish, setBusy, accept, curWalker;

  assign accept    = missValid && (!busyQ || missFromWalker);
  assign curWalker = (stQ == ST_IDLE) ? missFromWalker : fromWalkerQ;

  always_comb begin
    ctl.step = S_NONE; ctl.capture = 1'b0; ctl.clr = 1'b0;
    nxt = stQ; finish = 1'b0; fcode = F_NONE; setBusy = 1'b0;
    unique case (stQ)
      ST_IDLE: if (accept) begin
        if (boundsFail) begin
          finish = 1'b1; fcode = F_BOUNDS; ctl.clr = 1'b1;
        end else begin
          ctl.step = S_START; nxt = ST_FETCH;
        end
      end
      ST_FETCH: nxt = ST_WAIT;
      ST_WAIT: if (memMiss) begin
        setBusy = 1'b1; nxt = ST_IDLE;
      end else if (memDone) begin
        nxt = ST_IDLE;
        if (memFault) begin
          finish = 1'b1; fcode = F_WALK; ctl.clr = 1'b1;
        end else if (inPtrQ) begin
          if (ptrWordOk) begin
            ctl.step = S_PTRWORD; nxt = ST_FETCH;
          end else begin
            finish = 1'b1; fcode = F_NOACC; ctl.clr = 1'b1;
          end
        end else begin
          unique case (kind)
            K_PRIV: begin finish = 1'b1; ctl.capture = 1'b1; end
            K_SHARED, K_INDTBL, K_INDDIR: begin
              if (depthQ == DW'(MAX_DEPTH)) begin
                finish = 1'b1; fcode = F_DEEP; ctl.clr = 1'b1;
              end else begin
                nxt = ST_FETCH;
                ctl.step = (kind == K_SHARED) ? S_SHARED :
                           (kind == K_INDTBL) ? S_INDTBL : S_INDDIR;
              end
            end
            default: begin finish = 1'b1; fcode = F_NOACC; ctl.clr = 1'b1; end
          endcase
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ <= ST_IDLE; depthQ <= '0; inPtrQ <= 1'b0; fromWalkerQ <= 1'b0;
      busyQ <= 1'b0; validQ <= 1'b0; faultQ <= F_NONE;
    end else begin
      stQ    <= nxt;
      validQ <= finish;
      if (finish) faultQ <= fcode;
      if (ctl.step == S_START) begin
        depthQ <= '0; fromWalkerQ <= missFromWalker;
      end else if (ctl.step == S_SHARED || ctl.step == S_INDTBL || ctl.step == S_INDDIR) begin
        depthQ <= depthQ + 1'b1;
      end
      if (ctl.step != S_NONE) inPtrQ <= (ctl.step == S_INDTBL);
      if (setBusy) busyQ <= 1'b1;
      else if (finish && curWalker) busyQ <= 1'b0;
    end
  end

  assign memReq      = (stQ == ST_FETCH);
  assign refillValid = validQ;
  assign refillFault = faultQ;
  assign busy        = busyQ;

  p_req_one_cycle_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  p_bounds_nofetch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_IDLE && accept && boundsFail) |=> (!memReq && refillValid && refillFault == F_BOUNDS));
  p_busy_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_IDLE && busyQ && missValid && !missFromWalker) |=> (stQ == ST_IDLE));
  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    depthQ <= DW'(MAX_DEPTH));
endmodule

// File: rtl/ptw_refill.sv
module ptw_refill
  import ptw_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int IDX_W     = 13,
  parameter int LEN_W     = 11,
  parameter int MAX_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ptrWrEn,
  input  logic [3:0]              ptrWrIdx,
  input  logic [LEN_W+ADDR_W-1:0] ptrWrData,
  input  logic                    missValid,
  input  logic                    missFromWalker,
  input  logic [3:0]              missPtrSel,
  input  logic [IDX_W-1:0]        missPage,
  output logic                    memReq,
  output logic [ADDR_W-1:0]       memAddr,
  input  logic                    memDone,
  input  logic [35:0]             memData,
  input  logic                    memFault,
  input  logic                    memMiss,
  output logic                    refillValid,
  output logic [2:0]              refillPerm,
  output logic [12:0]             refillPage,
  output logic [2:0]              refillFault,
  output logic                    busy
);
  ctl_s  ctl;
  kind_e kind;
  logic  ptrWordOk, boundsFail;

  ptw_datapath #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) uDp (
    .clk, .rstN, .ptrWrEn, .ptrWrIdx, .ptrWrData, .missPtrSel, .missPage,
    .memData, .ctl, .memAddr, .kind, .ptrWordOk, .boundsFail,
    .refillPerm, .refillPage
  );

  ptw_control #(.MAX_DEPTH(MAX_DEPTH)) uCtl (
    .clk, .rstN, .missValid, .missFromWalker, .memDone, .memFault, .memMiss,
    .kind, .ptrWordOk, .boundsFail, .ctl, .memReq, .refillValid,
    .refillFault, .busy
  );
endmodule

// File: tb/tb_ptw_refill.sv
module tb_ptw_refill;
  logic clk = 0, rstN = 0;
  logic ptrWrEn = 0; logic [3:0] ptrWrIdx = 0; logic [32:0] ptrWrData = 0;
  logic missValid = 0, missFromWalker = 0; logic [3:0] missPtrSel = 0; logic [12:0] missPage = 0;
  logic memReq; logic [21:0] memAddr;
  logic memDone = 0, memFault = 0, memMiss = 0; logic [35:0] memData = 0;
  logic refillValid; logic [2:0] refillPerm; logic [12:0] refillPage; logic [2:0] refillFault;
  logic busy;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ptw_refill #(.MAX_DEPTH(2)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] mkPriv(input logic [2:0] p, input logic a, input logic [12:0] pg);
    return {2'b00, p, a, 17'b0, pg};
  endfunction
  function automatic logic [35:0] mkShared(input logic [2:0] p, input logic [12:0] spn);
    return {2'b01, p, 1'b1, 3'b0, spn, 14'b0};
  endfunction
  function automatic logic [35:0] mkInd(input logic [2:0] p, input logic [12:0] t, input logic [8:0] pn);
    return {2'b10, p, 1'b1, 3'b0, t, 5'b0, pn};
  endfunction
  function automatic logic [35:0] mkPtrWord(input logic [2:0] p, input logic a, input logic [21:0] b);
    return {2'b00, p, a, 8'b0, b};
  endfunction

  task automatic setPtr(input logic [3:0] i, input logic [10:0] len, input logic [21:0] base);
    @(negedge clk); ptrWrEn = 1; ptrWrIdx = i; ptrWrData = {len, base};
    @(negedge clk); ptrWrEn = 0;
  endtask

  task automatic miss(input logic [3:0] sel, input logic [12:0] pg, input logic w);
    @(negedge clk); missValid = 1; missPtrSel = sel; missPage = pg; missFromWalker = w;
    @(negedge clk); missValid = 0; missFromWalker = 0;
  endtask

  task automatic serve(input string tag, input logic [21:0] addr, input logic [35:0] d,
                       input logic flt, input logic ms);
    int n = 0;
    while (!memReq && n < 20) begin @(negedge clk); n++; end
    chk({tag, " memReq"}, 32'(memReq), 1);
    chk({tag, " memAddr"}, 32'(memAddr), 32'(addr));
    @(negedge clk); memDone = !ms; memMiss = ms; memFault = flt; memData = d;
    @(negedge clk); memDone = 0; memMiss = 0; memFault = 0;
  endtask

  task automatic result(input string tag, input logic [2:0] p, input logic [12:0] pg, input logic [2:0] f);
    chk({tag, " valid"}, 32'(refillValid), 1);
    chk({tag, " perm"}, 32'(refillPerm), 32'(p));
    chk({tag, " page"}, 32'(refillPage), 32'(pg));
    chk({tag, " fault"}, 32'(refillFault), 32'(f));
  endtask

  task automatic tReset;
    chk("R1 refillValid", 32'(refillValid), 0);
    chk("R1 memReq", 32'(memReq), 0);
    chk("R1 busy", 32'(busy), 0);
  endtask

  task automatic tPrivate;  // R2 R3
    miss(4, 5, 0);
    chk("R2 req next cycle", 32'(memReq), 1);
    serve("R2", 22'h1005, mkPriv(3'b101, 1, 13'h1ABC), 0, 0);
    result("R3 private", 3'b101, 13'h1ABC, 0);
    @(negedge clk); chk("R3 valid one cycle", 32'(refillValid), 0);
  endtask

  task automatic tNoAccess;  // R4, R8 exec ignores length
    miss(0, 7, 0);
    serve("R8 exec no bound", 22'h0807, mkPriv(3'b111, 0, 13'h55), 0, 0);
    result("R4 noaccess", 3'b000, 0, 1);
  endtask

  task automatic tShared;  // R5
    miss(4, 3, 0);
    serve("R5 first", 22'h1003, mkShared(3'b110, 13'h25), 0, 0);
    serve("R5 shared", 22'h3025, mkPriv(3'b111, 1, 13'h42), 0, 0);
    result("R5 narrowed", 3'b110, 13'h42, 0);
  endtask

  task automatic tIndTable;  // R6
    miss(4, 2, 0);
    serve("R6 first", 22'h1002, mkInd(3'b111, 13'h10, 9'h33), 0, 0);
    serve("R6 ptrtbl", 22'h4010, mkPtrWord(3'b011, 1, 22'h6000), 0, 0);
    serve("R6 newbase", 22'h6033, mkPriv(3'b111, 1, 13'h77), 0, 0);
    result("R6 indirect", 3'b011, 13'h77, 0);
    miss(4, 2, 0);
    serve("R6 first b", 22'h1002, mkInd(3'b111, 13'h11, 9'h01), 0, 0);
    serve("R6 ptrtbl b", 22'h4011, mkPtrWord(3'b111, 0, 22'h6000), 0, 0);
    result("R6 ptrword noaccess", 3'b000, 0, 1);
  endtask

  task automatic tIndDirect;  // R7
    miss(4, 1, 0);
    serve("R7 first", 22'h1001, mkInd(3'b101, {9'h1FF, 4'd9}, 9'h44), 0, 0);
    serve("R7 direct", 22'h5044, mkPriv(3'b111, 1, 13'h99), 0, 0);
    result("R7 direct", 3'b101, 13'h99, 0);
  endtask

  task automatic tBounds;  // R8
    miss(5, 11, 0);
    chk("R8 no memReq", 32'(memReq), 0);
    result("R8 bounds", 3'b000, 0, 4);
    miss(5, 10, 0);
    serve("R8 at limit", 22'h200A, mkPriv(3'b100, 1, 13'h3), 0, 0);
    result("R8 at limit", 3'b100, 13'h3, 0);
  endtask

  task automatic tDepth;  // R9
    miss(4, 0, 0);
    serve("R9 l0", 22'h1000, mkShared(3'b111, 13'h1), 0, 0);
    serve("R9 l1", 22'h3001, mkShared(3'b111, 13'h2), 0, 0);
    serve("R9 l2", 22'h3002, mkShared(3'b111, 13'h3), 0, 0);
    result("R9 too deep", 3'b000, 0, 2);
  endtask

  task automatic tWalkFault;  // R10
    miss(4, 8, 0);
    serve("R10", 22'h1008, mkPriv(3'b111, 1, 13'h5), 1, 0);
    result("R10 walk fault", 3'b000, 0, 3);
  endtask

  task automatic tBusy;  // R11
    miss(4, 6, 0);
    serve("R11 abandon", 22'h1006, 36'h0, 0, 1);
    chk("R11 no refill", 32'(refillValid), 0);
    chk("R11 busy set", 32'(busy), 1);
    miss(4, 6, 0);
    chk("R11 blocked", 32'(memReq), 0);
    @(negedge clk); chk("R11 still blocked", 32'(memReq), 0);
    miss(9, 0, 1);
    serve("R11 walker miss", 22'h5000, mkPriv(3'b111, 1, 13'h12), 0, 0);
    result("R11 walker refill", 3'b111, 13'h12, 0);
    chk("R11 busy clear", 32'(busy), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tReset();
    setPtr(4, 11'd100, 22'h1000);
    setPtr(5, 11'd10,  22'h2000);
    setPtr(6, 11'd0,   22'h3000);
    setPtr(7, 11'd0,   22'h4000);
    setPtr(9, 11'd0,   22'h5000);
    setPtr(0, 11'd0,   22'h0800);
    tPrivate();
    tNoAccess();
    tShared();
    tIndTable();
    tIndDirect();
    tBounds();
    tDepth();
    tWalkFault();
    tBusy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule